// File: doc/BRIEF.md
# Butterfly Path Allocator with Per-Element Arbitration

This block grants paths through a multistage butterfly fabric built from small two-by-two switching elements. Each of the N inputs may present one request per cycle, carrying a destination port index and a flag that marks it as a retry held in a switch-side buffer rather than a fresh speculative send. The block walks each request through log2(N) stages. At every stage one destination bit, taken most significant first, picks the element output. A request is granted only when it has won every element output along its path, and all requests are settled in one pass with no iterative matching.

Each element output carries at most one signal. When two requests want the same element output, a buffered request beats a new one. Between equals, a one-bit round-robin pointer held per element output decides. A pointer moves only when the path that used its output is granted end to end. Pipeline registers can sit after any stage, chosen by a bit mask. The grant vector and the fabric configuration word come out together, one register stage per set mask bit after the request.

Top module: `bfly_path_alloc`

## Requirements
- R1: After reset, grants and configuration are all zero, and every round-robin pointer prefers side 0, the input whose position bit for that stage is 0.
- R2: For a granted request from source S to destination D, stage s (with b = log2(N)-1-s) uses output position O_s. Bits b and above of O_s come from D and the bits below b come from S. Configuration bit cfg_en[s*N+O_s] is 1 and cfg_sel[s*N+O_s] equals bit b of S. cfg_sel is 0 wherever cfg_en is 0.
- R3: A request that is alone in its cycle is always granted.
- R4: Each element output is used by at most one granted path, so each stage shows exactly as many enabled outputs as there are grants.
- R5: When a buffered request (req_buf=1) and a new request contend for one element output, the buffered request wins regardless of the pointer.
- R6: Between contenders of equal priority, the pointer's preferred side wins. After a grant, that output's pointer prefers the other side.
- R7: A request that wins an early stage but loses a later one is not granted, and the pointers along its path stay unchanged.
- R8: The grant and the configuration word for a request appear together, exactly popcount(PIPE_MASK) cycles after the request, where bit s of the mask places a register after stage s. Before then they show nothing for it.
- R9: Inputs with req_vld=0 are ignored, whatever their destination or priority.
- R10: gnt[i] is raised only for input i, and only for a request that input made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | N | Request valid per input |
| req_buf | input | N | 1 = request comes from a switch buffer (high priority) |
| req_dst | input | N*log2(N) | Destination index per input, input i at bits i*log2(N) and up |
| gnt | output | N | Grant per input |
| cfg_en | output | log2(N)*N | Element output in use, index stage*N+position |
| cfg_sel | output | log2(N)*N | Input side routed to that element output |

## Verification
The assertions check on every cycle that grants only ever answer real requests from that input one latency earlier, and that a lone request is always granted. They also check that an idle history yields an empty configuration, that each stage uses exactly one element output per grant, and that side selects appear only on enabled outputs. Priority of buffered retries, the alternation of the round-robin pointers, and the rule that a path lost at a late stage leaves earlier pointers untouched all depend on sequences of contending patterns. Only the bench's directed scenarios and its pairwise and random sweeps, compared against an independent stage-by-stage model, can show those.

// File: rtl/bfly_path_alloc.sv
module bfly_path_alloc #(
  parameter int N = 64,
  parameter int unsigned PIPE_MASK = 32'h2A
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            req_vld,
  input  logic [N-1:0]            req_buf,
  input  logic [N*$clog2(N)-1:0]  req_dst,
  output logic [N-1:0]            gnt,
  output logic [N*$clog2(N)-1:0]  cfg_en,
  output logic [N*$clog2(N)-1:0]  cfg_sel
);
  localparam int L = $clog2(N);

  logic [N-1:0] v  [L+1];
  logic [N-1:0] pb [L+1];
  logic [L-1:0] ds [L+1][N];
  logic [L-1:0] sr [L+1][N];
  logic [N-1:0] ptr [L];

  assign v[0]  = req_vld;
  assign pb[0] = req_buf;

  for (genvar i = 0; i < N; i++) begin : g_in
    assign ds[0][i] = req_dst[i*L +: L];
    assign sr[0][i] = L'(i);
  end

  for (genvar s = 0; s < L; s++) begin : g_stage
    localparam int B = L - 1 - s;
    logic [N-1:0] cv, cb;
    logic [L-1:0] cd [N];
    logic [L-1:0] cs [N];

    for (genvar o = 0; o < N; o++) begin : g_out
      localparam int A0 = o & ~(1 << B);
      localparam int A1 = o | (1 << B);
      localparam bit OB = ((o >> B) & 1) != 0;
      logic c0, c1, pick1;
      assign c0 = v[s][A0] && (ds[s][A0][B] == OB);
      assign c1 = v[s][A1] && (ds[s][A1][B] == OB);
      assign pick1 = c1 && (!c0 || ((pb[s][A1] != pb[s][A0]) ? pb[s][A1] : ptr[s][o]));
      assign cv[o] = c0 | c1;
      assign cb[o] = pick1 ? pb[s][A1] : pb[s][A0];
      assign cd[o] = pick1 ? ds[s][A1] : ds[s][A0];
      assign cs[o] = pick1 ? sr[s][A1] : sr[s][A0];
    end

    if (((PIPE_MASK >> s) & 1) != 0) begin : g_reg
      logic [N-1:0] rv, rb;
      logic [L-1:0] rd [N];
      logic [L-1:0] rs [N];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rv <= '0;
          rb <= '0;
          for (int k = 0; k < N; k++) begin
            rd[k] <= '0;
            rs[k] <= '0;
          end
        end else begin
          rv <= cv;
          rb <= cb;
          for (int k = 0; k < N; k++) begin
            rd[k] <= cd[k];
            rs[k] <= cs[k];
          end
        end
      end
      assign v[s+1]  = rv;
      assign pb[s+1] = rb;
      for (genvar o = 0; o < N; o++) begin : g_fw
        assign ds[s+1][o] = rd[o];
        assign sr[s+1][o] = rs[o];
      end
    end else begin : g_comb
      assign v[s+1]  = cv;
      assign pb[s+1] = cb;
      for (genvar o = 0; o < N; o++) begin : g_fw
        assign ds[s+1][o] = cd[o];
        assign sr[s+1][o] = cs[o];
      end
    end
  end

  always_comb begin
    gnt     = '0;
    cfg_en  = '0;
    cfg_sel = '0;
    for (int p = 0; p < N; p++) begin
      if (v[L][p]) begin
        gnt[sr[L][p]] = 1'b1;
        for (int s = 0; s < L; s++) begin
          cfg_en[s*N + ((p & ~((1 << (L-1-s)) - 1)) | (int'(sr[L][p]) & ((1 << (L-1-s)) - 1)))] = 1'b1;
          cfg_sel[s*N + ((p & ~((1 << (L-1-s)) - 1)) | (int'(sr[L][p]) & ((1 << (L-1-s)) - 1)))] = sr[L][p][L-1-s];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < L; s++) ptr[s] <= '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        if (v[L][p]) begin
          for (int s = 0; s < L; s++)
            ptr[s][(p & ~((1 << (L-1-s)) - 1)) | (int'(sr[L][p]) & ((1 << (L-1-s)) - 1))] <= ~sr[L][p][L-1-s];
        end
      end
    end
  end
endmodule

// File: rtl/bfly_path_alloc_chk.sv
module bfly_path_alloc_chk #(
  parameter int N = 64,
  parameter int unsigned PIPE_MASK = 32'h2A
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N-1:0]           req_vld,
  input logic [N-1:0]           gnt,
  input logic [N*$clog2(N)-1:0] cfg_en,
  input logic [N*$clog2(N)-1:0] cfg_sel
);
  localparam int L = $clog2(N);

  function automatic int cnt_bits(int unsigned m, int n);
    int c = 0;
    for (int k = 0; k < n; k++) c += int'((m >> k) & 1);
    return c;
  endfunction

  localparam int LAT = cnt_bits(PIPE_MASK, L);

  logic [N-1:0] hreg [LAT+1];
  logic [N-1:0] old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= LAT; k++) hreg[k] <= '0;
    end else begin
      hreg[0] <= req_vld;
      for (int k = 1; k <= LAT; k++) hreg[k] <= hreg[k-1];
    end
  end

  if (LAT == 0) begin : g_l0
    assign old = req_vld;
  end else begin : g_ln
    assign old = hreg[LAT-1];
  end

  p_grant_from_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~old) == '0);

  p_lone_request_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(old) == 1) |-> (gnt == old));

  p_idle_no_config_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (old == '0) |-> (gnt == '0 && cfg_en == '0));

  p_sel_on_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel & ~cfg_en) == '0);

  for (genvar s = 0; s < L; s++) begin : g_use
    p_stage_usage_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cfg_en[s*N +: N]) == $countones(gnt));
  end
endmodule

bind bfly_path_alloc bfly_path_alloc_chk #(.N(N), .PIPE_MASK(PIPE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .gnt(gnt), .cfg_en(cfg_en), .cfg_sel(cfg_sel));

// File: tb/sim_bfly_path_alloc.sv
`timescale 1ns/1ps
module sim_bfly_path_alloc;
  localparam int N = 8;
  localparam int L = 3;
  localparam int unsigned PIPE = 32'h5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_vld = '0, req_buf = '0;
  logic [N*L-1:0] req_dst = '0;
  logic [N-1:0] gnt;
  logic [N*L-1:0] cfg_en, cfg_sel;

  int n_chk = 0, n_bad = 0;
  bit ptr_m [L][N];
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2 clk = ~clk;

  bfly_path_alloc #(.N(N), .PIPE_MASK(PIPE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_buf(req_buf), .req_dst(req_dst),
    .gnt(gnt), .cfg_en(cfg_en), .cfg_sel(cfg_sel));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic run(input logic [N-1:0] v, input logic [N-1:0] bf, input logic [N*L-1:0] d,
                     input string tag, output logic [N-1:0] got);
    int pos [N];
    int tg [L][N];
    bit alive [N];
    logic [N-1:0] eg = '0;
    logic [N*L-1:0] een = '0, esel = '0;
    for (int i = 0; i < N; i++) begin alive[i] = v[i]; pos[i] = i; end
    for (int s = 0; s < L; s++) begin
      int b = L - 1 - s;
      for (int i = 0; i < N; i++)
        if (alive[i]) tg[s][i] = (pos[i] & ~(1 << b)) | (int'(d[i*L +: L]) & (1 << b));
      for (int i = 0; i < N; i++)
        for (int j = i + 1; j < N; j++)
          if (alive[i] && alive[j] && tg[s][i] == tg[s][j]) begin
            bit iw;
            if (bf[i] != bf[j]) iw = bf[i];
            else iw = (int'(ptr_m[s][tg[s][i]]) == ((pos[i] >> b) & 1));
            if (iw) alive[j] = 0; else alive[i] = 0;
          end
      for (int i = 0; i < N; i++) if (alive[i]) pos[i] = tg[s][i];
    end
    for (int i = 0; i < N; i++)
      if (alive[i]) begin
        eg[i] = 1'b1;
        for (int s = 0; s < L; s++) begin
          een[s*N + tg[s][i]] = 1'b1;
          esel[s*N + tg[s][i]] = 1'(((i >> (L-1-s)) & 1));
        end
      end
    @(negedge clk);
    req_vld = v; req_buf = bf; req_dst = d;
    @(posedge clk);
    @(negedge clk);
    req_vld = '0; req_buf = '0; req_dst = '0;
    chk(gnt === '0 && cfg_en === '0, {tag, " R8 early"}, 64'(gnt), 64'd0);
    @(posedge clk);
    @(negedge clk);
    got = gnt;
    chk(gnt === eg, {tag, " R10 gnt"}, 64'(gnt), 64'(eg));
    chk(cfg_en === een && cfg_sel === esel, {tag, " R2 cfg"}, 64'({cfg_en, cfg_sel}), 64'({een, esel}));
    for (int i = 0; i < N; i++)
      if (alive[i])
        for (int s = 0; s < L; s++) ptr_m[s][tg[s][i]] = 1'(1 - ((i >> (L-1-s)) & 1));
  endtask

  function automatic logic [N*L-1:0] put(input logic [N*L-1:0] d, input int i, input int x);
    logic [N*L-1:0] r = d;
    r[i*L +: L] = L'(x);
    return r;
  endfunction

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] g;
    logic [N*L-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(gnt === '0 && cfg_en === '0 && cfg_sel === '0, "R1 reset outputs", 64'(gnt), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt === '0 && cfg_en === '0, "R1 idle after reset", 64'(gnt), 64'd0);

    d = put('0, 3, 5);
    run(8'h08, 8'h00, d, "R3 lone", g);
    chk(g === 8'h08, "R3 lone granted", 64'(g), 64'h08);
    chk(cfg_en === 24'h20_2080, "R2 lone path", 64'(cfg_en), 64'h202080);

    d = put(put(put('0, 6, 2), 4, 0), 0, 3);
    run(8'h51, 8'h40, d, "R7 late loss", g);
    chk(g === 8'h40, "R7 buffered wins stage 1", 64'(g), 64'h40);
    d = put(put('0, 4, 0), 0, 3);
    run(8'h11, 8'h00, d, "R7 pointer kept", g);
    chk(g === 8'h01, "R7 stage-0 pointer unchanged", 64'(g), 64'h01);
    run(8'h11, 8'h00, d, "R6 alternate", g);
    chk(g === 8'h10, "R6 round robin flips", 64'(g), 64'h10);
    run(8'h11, 8'h10, d, "R5 buffered", g);
    chk(g === 8'h10, "R5 buffered beats pointer", 64'(g), 64'h10);
    run(8'h10, 8'h01, d, "R9 invalid", g);
    chk(g === 8'h10, "R9 invalid contender ignored", 64'(g), 64'h10);

    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        for (int da = 0; da < N; da++)
          for (int db = 0; db < N; db++) begin
            d = put(put('0, a, da), b, db);
            run(N'(1 << a) | N'(1 << b), ((da + db) % 3 == 0) ? N'(1 << b) : '0, d, "R4 R5 R6 pair", g);
          end

    for (int k = 0; k < 600; k++) begin
      lfsr = nxt(nxt(lfsr));
      d = N*L'(lfsr);
      lfsr = nxt(lfsr);
      run(lfsr[7:0], lfsr[15:8], d, "R4 R6 R7 R9 random", g);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule